// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block lets a general-purpose input pin act as a source for an active-low interrupt line. The pin arrives asynchronously. The block synchronises it and compares it with its previous synchronised value to find transitions. It then decides, on every clock, whether the interrupt line should be driven low. The decision uses one of four trigger modes: low level, high level, rising edge or falling edge.

The pin setup field, the trigger-mode field and the enable bit come from a register bank. Each clock they are captured into a configuration register that reset clears. The block also keeps a sticky status flag. A host clears this flag with a one-cycle read strobe, but the clear only takes effect when the pin is no longer triggering. A level that is still active, or an edge seen in the same cycle as the read, keeps the flag set.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is held and after its release with no trigger, `irq_n` reads 1 and `irq_status` reads 0.
- R2: When the captured pin setup field is anything other than 2'b01 (input), the pin never drives `irq_n` low and never sets `irq_status`.
- R3: With the captured enable bit at 0, the pin never drives `irq_n` low and never sets `irq_status`.
- R4: Trigger mode 2'b00 (low level): `irq_n` is low for every cycle the synchronised pin is 0, starting three clock edges after the pin falls, and `irq_status` reads 1 over the same cycles.
- R5: Trigger mode 2'b11 (high level): `irq_n` is low for every cycle the synchronised pin is 1, starting three clock edges after the pin rises, and `irq_status` reads 1 over the same cycles.
- R6: Trigger mode 2'b01 (rising edge): a 0-to-1 pin transition gives exactly one low cycle on `irq_n`, three edges after the transition, and sets `irq_status`. A 1-to-0 transition has no effect.
- R7: Trigger mode 2'b10 (falling edge): a 1-to-0 pin transition gives exactly one low cycle on `irq_n`, three edges after the transition, and sets `irq_status`. A 0-to-1 transition has no effect.
- R8: Once set, `irq_status` stays at 1 until a `status_rd` strobe with no trigger present. After that strobe it reads 0 from the next clock.
- R9: A `status_rd` strobe while a level trigger is still active leaves `irq_status` at 1.
- R10: A `status_rd` strobe in the same cycle as a new edge event leaves `irq_status` at 1.
- R11: A pin held steady through reset gives no edge trigger after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_async | input | 1 | Raw general-purpose pin, asynchronous to `clk` |
| pin_setup | input | 2 | Pin setup field; 2'b01 selects input use |
| trig_mode | input | 2 | Trigger mode: 00 low level, 01 rising, 10 falling, 11 high level |
| irq_en | input | 1 | Interrupt enable, 1 = enabled |
| status_rd | input | 1 | One-cycle read strobe of the status flag |
| irq_status | output | 1 | Sticky status flag |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
A corrupt trigger decision shows up on `irq_n` and `irq_status` at the third clock edge after the pin changes, because the path has two synchroniser flops and one output register. A wrong edge-history value shows as a missing pulse, an extra pulse, or a pulse longer than one cycle within that same window. A bad status-clear condition shows one clock after a read strobe: the flag either survives a read it should not survive, or is lost during an active level or a coincident edge.

// File: rtl/gpio_irq_pkg.sv
// Package: shared encodings for the GPIO interrupt controller.
// Assumes the configuration fields are two bits wide, as decoded here.
package gpio_irq_pkg;

    localparam int CFG_W = 2;

    // Trigger selection. Bit values are decoded by the detector.
    typedef enum logic [CFG_W-1:0] {
        TRIG_LOW_LVL  = 2'b00,
        TRIG_RISE     = 2'b01,
        TRIG_FALL     = 2'b10,
        TRIG_HIGH_LVL = 2'b11
    } trig_mode_e;

    // Pin setup code that turns the pin into an input.
    localparam logic [CFG_W-1:0] SETUP_AS_INPUT = 2'b01;

    // Captured configuration word.
    typedef struct packed {
        logic [CFG_W-1:0] setup;
        trig_mode_e       mode;
        logic             en;
    } irq_cfg_t;

endpackage

// File: rtl/gpio_irq_sync.sv
// Module: synchroniser and edge-history stage for the GPIO pin.
// The flop chain is STAGES deep (at least 2). It runs without reset so that
// the history register already matches the settled pin level when reset is
// released. Assumes the pin is held steady for STAGES+1 cycles of reset.
module gpio_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_async,
    output logic pin_sync,
    output logic pin_prev
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("gpio_irq_sync: STAGES must be at least 2");
        end
    endgenerate

    // Purpose: shift the raw pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], pin_async};
    end

    assign pin_sync = chain[STAGES-1];

    // Purpose: keep the previous synchronised value for edge comparison.
    always_ff @(posedge clk) begin
        pin_prev <= pin_sync;
    end

endmodule

// File: rtl/gpio_irq_detect.sv
// Module: combinational trigger decision.
// Combines the captured configuration with the synchronised pin and its
// history, and raises trig in any cycle where the selected condition holds.
// Edge modes fire for one cycle per transition. Level modes fire for as
// long as the level holds.
module gpio_irq_detect
    import gpio_irq_pkg::*;
(
    input  irq_cfg_t cfg,
    input  logic     pin_sync,
    input  logic     pin_prev,
    output logic     trig
);

    logic armed;
    logic rise_evt;
    logic fall_evt;
    logic hit;

    assign armed    = cfg.en && (cfg.setup == SETUP_AS_INPUT);
    assign rise_evt = pin_sync && !pin_prev;
    assign fall_evt = !pin_sync && pin_prev;

    // Purpose: choose the trigger condition from the mode field.
    always_comb begin
        case (cfg.mode)
            TRIG_LOW_LVL:  hit = !pin_sync;
            TRIG_RISE:     hit = rise_evt;
            TRIG_FALL:     hit = fall_evt;
            TRIG_HIGH_LVL: hit = pin_sync;
            default:       hit = 1'b0;
        endcase
    end

    assign trig = armed && hit;

endmodule

// File: rtl/gpio_irq_status.sv
// Module: sticky status flag and registered active-low interrupt output.
// A set takes priority over a clear, so a read in a trigger cycle loses
// nothing. Assumes rd is a single-cycle strobe.
module gpio_irq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic rd,
    output logic status_q,
    output logic irq_n_q
);

    // Purpose: set on trigger, clear on read only when no trigger is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (trig) begin
            status_q <= 1'b1;
        end else if (rd) begin
            status_q <= 1'b0;
        end
    end

    // Purpose: drive the interrupt line low in each cycle after a trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n_q <= 1'b1;
        end else begin
            irq_n_q <= !trig;
        end
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
// Module: top level of the GPIO interrupt controller.
// Captures the configuration fields every clock (reset disables), then
// synchronises the pin, detects the trigger and drives the status flag
// and the active-low interrupt. Pin-to-output latency is three edges.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_async,
    input  logic [CFG_W-1:0] pin_setup,
    input  logic [CFG_W-1:0] trig_mode,
    input  logic             irq_en,
    input  logic             status_rd,
    output logic             irq_status,
    output logic             irq_n
);

    irq_cfg_t cfg_q;
    logic     pin_sync;
    logic     pin_prev;
    logic     trig;

    // Purpose: capture the register-bank fields; reset leaves the source disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.setup <= '0;
            cfg_q.mode  <= TRIG_LOW_LVL;
            cfg_q.en    <= 1'b0;
        end else begin
            cfg_q.setup <= pin_setup;
            cfg_q.mode  <= trig_mode_e'(trig_mode);
            cfg_q.en    <= irq_en;
        end
    end

    gpio_irq_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .pin_async(pin_async),
        .pin_sync (pin_sync),
        .pin_prev (pin_prev)
    );

    gpio_irq_detect u_detect (
        .cfg     (cfg_q),
        .pin_sync(pin_sync),
        .pin_prev(pin_prev),
        .trig    (trig)
    );

    gpio_irq_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (trig),
        .rd      (status_rd),
        .status_q(irq_status),
        .irq_n_q (irq_n)
    );

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
// Module: assertion checker for gpio_irq_ctrl, attached by bind below.
// Watches the captured configuration, the trigger decision and the outputs.
module gpio_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_setup,
    input logic [1:0] cfg_mode,
    input logic       cfg_en,
    input logic       trig,
    input logic       rd,
    input logic       status_q,
    input logic       irq_n
);

    // R2: a pin not set up as input cannot pull the interrupt low.
    assert_setup_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_setup != 2'b01) |=> irq_n);

    // R3: a disabled source cannot pull the interrupt low.
    assert_enable_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en) |=> irq_n);

    // R4/R5: a low interrupt always comes with the status flag set.
    assert_low_implies_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n) |-> status_q);

    // R6/R7: with an unchanged edge mode, a low pulse lasts one cycle.
    assert_edge_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && $stable(cfg_mode) && (cfg_mode[0] ^ cfg_mode[1])) |=> irq_n);

    // R8: a read with no trigger present clears the flag.
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q && rd && !trig) |=> !status_q);

    // R8: the flag does not rise without a trigger.
    assert_no_spurious_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_q && !trig) |=> !status_q);

    // R9/R10: a trigger always leaves the flag set, even with a read.
    assert_trig_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> status_q);

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_setup(cfg_q.setup),
    .cfg_mode (cfg_q.mode),
    .cfg_en   (cfg_q.en),
    .trig     (trig),
    .rd       (status_rd),
    .status_q (irq_status),
    .irq_n    (irq_n)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_async = 1'b0;
    logic [1:0] pin_setup = 2'b00;
    logic [1:0] trig_mode = 2'b00;
    logic       irq_en = 1'b0;
    logic       status_rd = 1'b0;
    logic       irq_status;
    logic       irq_n;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    gpio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_async),
        .pin_setup(pin_setup), .trig_mode(trig_mode), .irq_en(irq_en),
        .status_rd(status_rd), .irq_status(irq_status), .irq_n(irq_n)
    );

    // Vector: req, setup, mode, en, pin before, pin after, low count in 8 samples, status at end
    typedef struct packed {
        logic [7:0] req;
        logic [1:0] setup;
        logic [1:0] mode;
        logic       en;
        logic       pin_a;
        logic       pin_b;
        logic [3:0] low_cnt;
        logic       stat;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{8'd6, 2'b01, 2'b01, 1'b1, 1'b0, 1'b1, 4'd1, 1'b1},  // R6 rise fires
        '{8'd6, 2'b01, 2'b01, 1'b1, 1'b1, 1'b0, 4'd0, 1'b0},  // R6 fall ignored
        '{8'd7, 2'b01, 2'b10, 1'b1, 1'b1, 1'b0, 4'd1, 1'b1},  // R7 fall fires
        '{8'd7, 2'b01, 2'b10, 1'b1, 1'b0, 1'b1, 4'd0, 1'b0},  // R7 rise ignored
        '{8'd4, 2'b01, 2'b00, 1'b1, 1'b1, 1'b0, 4'd6, 1'b1},  // R4 low level
        '{8'd4, 2'b01, 2'b00, 1'b1, 1'b1, 1'b1, 4'd0, 1'b0},  // R4 stays high
        '{8'd5, 2'b01, 2'b11, 1'b1, 1'b0, 1'b1, 4'd6, 1'b1},  // R5 high level
        '{8'd5, 2'b01, 2'b11, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0},  // R5 stays low
        '{8'd2, 2'b00, 2'b01, 1'b1, 1'b0, 1'b1, 4'd0, 1'b0},  // R2 setup 00
        '{8'd2, 2'b10, 2'b11, 1'b1, 1'b0, 1'b1, 4'd0, 1'b0},  // R2 setup 10
        '{8'd2, 2'b11, 2'b00, 1'b1, 1'b1, 1'b0, 4'd0, 1'b0},  // R2 setup 11
        '{8'd3, 2'b01, 2'b01, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0},  // R3 disabled edge
        '{8'd3, 2'b01, 2'b00, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0}   // R3 disabled level
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_read();
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
    endtask

    task automatic do_reset(input logic pin);
        rst_n = 1'b0;
        pin_async = pin;
        status_rd = 1'b0;
        cycles(5);
        rst_n = 1'b1;
    endtask

    initial begin
        int lows;
        do_reset(1'b0);
        // R1: state during reset
        rst_n = 1'b0;
        pin_setup = 2'b01; trig_mode = 2'b00; irq_en = 1'b1;
        cycles(3);
        check("R1", "irq_n in reset", irq_n, 1);
        check("R1", "status in reset", irq_status, 0);
        irq_en = 1'b0;
        rst_n = 1'b1;
        cycles(4);
        check("R1", "irq_n after reset", irq_n, 1);
        check("R1", "status after reset", irq_status, 0);

        // Vector walk
        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[v].req);
            pin_setup = VECS[v].setup;
            trig_mode = VECS[v].mode;
            irq_en    = VECS[v].en;
            pin_async = VECS[v].pin_a;
            cycles(6);
            pulse_read();
            cycles(2);
            pin_async = VECS[v].pin_b;
            lows = 0;
            for (int s = 0; s < 8; s++) begin
                @(negedge clk);
                if (!irq_n) lows++;
            end
            check(tag, $sformatf("vec %0d low cycles", v), lows, VECS[v].low_cnt);
            check(tag, $sformatf("vec %0d status", v), irq_status, VECS[v].stat);
            check(tag, $sformatf("vec %0d irq_n at end", v), irq_n,
                  (VECS[v].low_cnt == 4'd6) ? 0 : 1);
        end

        // R8: sticky until read, cleared by read without trigger
        pin_setup = 2'b01; trig_mode = 2'b01; irq_en = 1'b1; pin_async = 1'b0;
        cycles(6); pulse_read(); cycles(2);
        pin_async = 1'b1;
        cycles(10);
        check("R8", "status held after edge", irq_status, 1);
        check("R8", "irq_n idle after pulse", irq_n, 1);
        pulse_read();
        check("R8", "status after read", irq_status, 0);

        // R9: read during active level keeps status
        trig_mode = 2'b11;
        cycles(6);
        check("R9", "level low output", irq_n, 0);
        pulse_read();
        cycles(1);
        check("R9", "status after read in level", irq_status, 1);
        pin_async = 1'b0;
        cycles(5);
        check("R9", "irq_n released", irq_n, 1);
        pulse_read();
        check("R9", "status cleared when level gone", irq_status, 0);

        // R10: read in same cycle as a new rising edge
        trig_mode = 2'b01;
        cycles(6); pulse_read(); cycles(2);
        check("R10", "status clear before edge", irq_status, 0);
        pin_async = 1'b1;
        @(negedge clk);           // after edge 1: first sync flop
        @(negedge clk);           // after edge 2: trigger present
        status_rd = 1'b1;
        @(negedge clk);           // after edge 3: read and edge coincide
        status_rd = 1'b0;
        check("R10", "irq_n pulse at coincident read", irq_n, 0);
        check("R10", "status kept", irq_status, 1);
        cycles(2);
        check("R10", "status still set", irq_status, 1);

        // R11: pin high through reset, rising mode armed right after release
        pin_setup = 2'b01; trig_mode = 2'b01; irq_en = 1'b1;
        do_reset(1'b1);
        lows = 0;
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            if (!irq_n) lows++;
        end
        check("R11", "pulses after reset", lows, 0);
        check("R11", "status after reset", irq_status, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule